// File: doc/BRIEF.md
# Operand-Handshake Computation Unit Controller

This controller sits in front of a 16-bit execution unit and follows one operation from the moment it is issued until its result has been committed. When the issue strobe is sampled high, it stores the operation fields and raises busy. It then asks for each source operand it needs through a release/go pair on that read port. Each operand is handed to the execution unit in the cycle its go arrives. When every needed operand is in, the controller fires a one-cycle start pulse. It captures the unit's result when the unit flags it valid, in that cycle or in a later one.

The stored result then waits behind a write release. Busy stays high until a write-go pulse confirms that the result was stored. A result is therefore never dropped, and the unit is never left unaccounted for. Operand A can be forced to zero and/or bit-inverted. Operand B can be replaced by an immediate. Any port can be masked so that it is never read.

Top module: `opcu_ctrl`

## Requirements
- R1: `busy_o` is low after reset and stays low in every cycle that follows a cycle with `busy_o` and `issue_i` both low. After `issue_i` is sampled high while idle, `busy_o` is high in the next cycle.
- R2: The opcode, invert flag, zero flag, immediate value and immediate-valid flag are captured in the issue cycle. Changing these inputs afterwards does not change the result.
- R3: In the cycle after issue, `rd_rel_o[p]` is high for every port that needs a read. It stays high for as many cycles as `rd_go_i[p]` is withheld.
- R4: While `rd_rel_o[p]` and `rd_go_i[p]` are both high, `eu_opnd_o[p]` is driven from that port's slice of `src_i` in the same cycle. `rd_rel_o[p]` is low in the next cycle. A go on a port whose release is low has no effect.
- R5: Port 0 (operand A) is not requested when the zero flag is set. Port 1 (operand B) is not requested when the immediate is valid. No port whose `rd_mask_i` bit is set at issue is requested. A zeroed A is 0, a valid immediate replaces B, and any other unread operand is 0.
- R6: With the invert flag set, operand A is bit-complemented after zeroing. At 16 bits, inverted 5 plus 2 is 65532.
- R7: `eu_go_o` is a single-cycle pulse issued once no read release remains open. The result is captured when `eu_vld_i` is high, in the same cycle as `eu_go_o` (zero latency) or later.
- R8: `wr_rel_o` and `busy_o` stay high, and `data_o` holds the captured result, until `wr_go_i` is sampled high. In the next cycle both `wr_rel_o` and `busy_o` are low.
- R9: An operation needing no reads (zero flag, valid immediate and port 2 masked) reaches the write release without any read release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe; accepted while idle |
| opc_i | input | OPC_W | Opcode passed on to the execution unit |
| inv_a_i | input | 1 | Bit-invert operand A |
| zero_a_i | input | 1 | Force operand A to zero, skip its read |
| imm_i | input | DATA_W | Immediate value for operand B |
| imm_vld_i | input | 1 | Immediate replaces operand B, skip its read |
| rd_mask_i | input | NUM_RD | Per-port read suppression, held while busy |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | NUM_RD | Per-port read release |
| rd_go_i | input | NUM_RD | Per-port read go |
| src_i | input | NUM_RD*DATA_W | Operand data, port p in bits p*DATA_W upward |
| eu_go_o | output | 1 | Start pulse to the execution unit |
| eu_opc_o | output | OPC_W | Captured opcode |
| eu_opnd_o | output | NUM_RD*DATA_W | Formatted operands, same packing as src_i |
| eu_vld_i | input | 1 | Execution unit result valid |
| eu_res_i | input | DATA_W | Execution unit result |
| wr_rel_o | output | 1 | Result ready for write-back |
| wr_go_i | input | 1 | Write-back done pulse |
| data_o | output | DATA_W | Captured result |

## Verification
The bench builds the controller with its defaults: 16-bit data, a 4-bit opcode and three read ports. At 16 bits the inverted-operand wrap to 65532 can be checked. The third port allows a mix of masked and unmasked reads alongside the zero and immediate skips, including the case where no read is needed at all. The execution-unit model in the bench has a latency that can be changed between tests. This lets the same controller be run against a combinational result and a result delayed by several cycles.

// File: rtl/opcu_pkg.sv
package opcu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EXEC,
        ST_WAIT,
        ST_WRITE
    } seq_st_e;

    typedef struct packed {
        logic inv_a;
        logic zero_a;
        logic imm_vld;
    } op_ctl_t;

    // Decide whether a read port must be requested for this operation
    function automatic logic port_needed(input op_ctl_t ctl, input logic masked, input int idx);
        logic need;
        need = !masked;
        if (idx == 0 && ctl.zero_a)  need = 1'b0;
        if (idx == 1 && ctl.imm_vld) need = 1'b0;
        return need;
    endfunction

endpackage

// File: rtl/opcu_rd_port.sv
module opcu_rd_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              need_i,
    input  logic              go_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              rel_o,
    output logic              take_o,
    output logic [DATA_W-1:0] val_o
);
    logic              rel_q;
    logic [DATA_W-1:0] opnd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_q  <= 1'b0;
            opnd_q <= '0;
        end else if (arm_i) begin
            rel_q  <= need_i;
            opnd_q <= '0;
        end else if (rel_q && go_i) begin
            rel_q  <= 1'b0;
            opnd_q <= src_i;
        end
    end

    assign take_o = rel_q && go_i;
    assign rel_o  = rel_q;
    assign val_o  = take_o ? src_i : opnd_q;
endmodule

// File: rtl/opcu_opnd_fmt.sv
module opcu_opnd_fmt
    import opcu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_RD = 3
) (
    input  op_ctl_t                   ctl_i,
    input  logic [DATA_W-1:0]         imm_i,
    input  logic [NUM_RD*DATA_W-1:0]  raw_i,
    output logic [NUM_RD*DATA_W-1:0]  opnd_o
);
    for (genvar p = 0; p < NUM_RD; p++) begin : g_fmt
        if (p == 0) begin : g_a
            logic [DATA_W-1:0] a_base;
            assign a_base = ctl_i.zero_a ? '0 : raw_i[0 +: DATA_W];
            assign opnd_o[0 +: DATA_W] = ctl_i.inv_a ? ~a_base : a_base;
        end else if (p == 1) begin : g_b
            assign opnd_o[DATA_W +: DATA_W] = ctl_i.imm_vld ? imm_i : raw_i[DATA_W +: DATA_W];
        end else begin : g_pass
            assign opnd_o[p*DATA_W +: DATA_W] = raw_i[p*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/opcu_seq.sv
module opcu_seq
    import opcu_pkg::*;
#(
    parameter int NUM_RD = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [NUM_RD-1:0] rel_i,
    input  logic [NUM_RD-1:0] take_i,
    input  logic              eu_vld_i,
    input  logic              wr_go_i,
    output logic              accept_o,
    output logic              eu_go_o,
    output logic              cap_o,
    output logic              wr_rel_o,
    output logic              busy_o
);
    seq_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (issue_i) st_d = ST_READ;
            ST_READ:  if ((rel_i & ~take_i) == '0) st_d = ST_EXEC;
            ST_EXEC:  st_d = eu_vld_i ? ST_WRITE : ST_WAIT;
            ST_WAIT:  if (eu_vld_i) st_d = ST_WRITE;
            ST_WRITE: if (wr_go_i) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign accept_o = (st_q == ST_IDLE) && issue_i;
    assign eu_go_o  = (st_q == ST_EXEC);
    assign cap_o    = ((st_q == ST_EXEC) || (st_q == ST_WAIT)) && eu_vld_i;
    assign wr_rel_o = (st_q == ST_WRITE);
    assign busy_o   = (st_q != ST_IDLE);
endmodule

// File: rtl/opcu_ctrl.sv
module opcu_ctrl
    import opcu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    parameter int NUM_RD = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_i,
    input  logic [OPC_W-1:0]          opc_i,
    input  logic                      inv_a_i,
    input  logic                      zero_a_i,
    input  logic [DATA_W-1:0]         imm_i,
    input  logic                      imm_vld_i,
    input  logic [NUM_RD-1:0]         rd_mask_i,
    output logic                      busy_o,
    output logic [NUM_RD-1:0]         rd_rel_o,
    input  logic [NUM_RD-1:0]         rd_go_i,
    input  logic [NUM_RD*DATA_W-1:0]  src_i,
    output logic                      eu_go_o,
    output logic [OPC_W-1:0]          eu_opc_o,
    output logic [NUM_RD*DATA_W-1:0]  eu_opnd_o,
    input  logic                      eu_vld_i,
    input  logic [DATA_W-1:0]         eu_res_i,
    output logic                      wr_rel_o,
    input  logic                      wr_go_i,
    output logic [DATA_W-1:0]         data_o
);
    localparam int OPND_W = NUM_RD * DATA_W;

    logic                accept;
    logic                cap;
    logic [NUM_RD-1:0]   take;
    logic [NUM_RD-1:0]   need;
    logic [OPND_W-1:0]   raw_val;
    op_ctl_t             ctl_in, ctl_q;
    logic [OPC_W-1:0]    opc_q;
    logic [DATA_W-1:0]   imm_q;
    logic [DATA_W-1:0]   res_q;

    assign ctl_in = '{inv_a: inv_a_i, zero_a: zero_a_i, imm_vld: imm_vld_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            opc_q <= '0;
            imm_q <= '0;
        end else if (accept) begin
            ctl_q <= ctl_in;
            opc_q <= opc_i;
            imm_q <= imm_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      res_q <= '0;
        else if (cap) res_q <= eu_res_i;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        assign need[p] = port_needed(ctl_in, rd_mask_i[p], p);

        opcu_rd_port #(.DATA_W(DATA_W)) u_port (
            .clk    (clk),
            .rst    (rst),
            .arm_i  (accept),
            .need_i (need[p]),
            .go_i   (rd_go_i[p]),
            .src_i  (src_i[p*DATA_W +: DATA_W]),
            .rel_o  (rd_rel_o[p]),
            .take_o (take[p]),
            .val_o  (raw_val[p*DATA_W +: DATA_W])
        );
    end

    opcu_opnd_fmt #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_fmt (
        .ctl_i  (ctl_q),
        .imm_i  (imm_q),
        .raw_i  (raw_val),
        .opnd_o (eu_opnd_o)
    );

    opcu_seq #(.NUM_RD(NUM_RD)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .issue_i  (issue_i),
        .rel_i    (rd_rel_o),
        .take_i   (take),
        .eu_vld_i (eu_vld_i),
        .wr_go_i  (wr_go_i),
        .accept_o (accept),
        .eu_go_o  (eu_go_o),
        .cap_o    (cap),
        .wr_rel_o (wr_rel_o),
        .busy_o   (busy_o)
    );

    assign eu_opc_o = opc_q;
    assign data_o   = res_q;
endmodule

// File: rtl/opcu_ctrl_chk.sv
module opcu_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int NUM_RD = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_i,
    input logic              zero_a_i,
    input logic              busy_o,
    input logic [NUM_RD-1:0] rd_rel_o,
    input logic [NUM_RD-1:0] rd_go_i,
    input logic              eu_go_o,
    input logic              wr_rel_o,
    input logic              wr_go_i,
    input logic [DATA_W-1:0] data_o
);
    AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !issue_i) |=> !busy_o); // R1
    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && issue_i) |=> busy_o); // R1
    AST_REL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (rd_rel_o != '0) |-> busy_o); // R3
    AST_ZERO_A_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && issue_i && zero_a_i) |=> !rd_rel_o[0]); // R5
    AST_EU_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
        eu_go_o |=> !eu_go_o); // R7
    AST_EU_GO_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
        eu_go_o |-> (rd_rel_o == '0)); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_rel_o && !wr_go_i) |=> (wr_rel_o && busy_o && $stable(data_o))); // R8
    AST_WR_DONE: assert property (@(posedge clk) disable iff (rst)
        (wr_rel_o && wr_go_i) |=> (!busy_o && !wr_rel_o)); // R8

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rel
        AST_REL_HOLD: assert property (@(posedge clk) disable iff (rst)
            (rd_rel_o[p] && !rd_go_i[p]) |=> rd_rel_o[p]); // R3
        AST_REL_DROP: assert property (@(posedge clk) disable iff (rst)
            (rd_rel_o[p] && rd_go_i[p]) |=> !rd_rel_o[p]); // R4
    end
endmodule

bind opcu_ctrl opcu_ctrl_chk #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .issue_i  (issue_i),
    .zero_a_i (zero_a_i),
    .busy_o   (busy_o),
    .rd_rel_o (rd_rel_o),
    .rd_go_i  (rd_go_i),
    .eu_go_o  (eu_go_o),
    .wr_rel_o (wr_rel_o),
    .wr_go_i  (wr_go_i),
    .data_o   (data_o)
);

// File: tb/opcu_ctrl_tb.sv
module opcu_ctrl_tb;
    localparam int DW = 16;
    localparam int OW = 4;
    localparam int NR = 3;

    logic           clk = 1'b0;
    logic           rst;
    logic           issue_i = 0;
    logic [OW-1:0]  opc_i = '0;
    logic           inv_a_i = 0, zero_a_i = 0, imm_vld_i = 0;
    logic [DW-1:0]  imm_i = '0;
    logic [NR-1:0]  rd_mask_i = '0;
    logic           busy_o;
    logic [NR-1:0]  rd_rel_o;
    logic [NR-1:0]  rd_go_i = '0;
    logic [NR*DW-1:0] src_i = '0;
    logic           eu_go_o;
    logic [OW-1:0]  eu_opc_o;
    logic [NR*DW-1:0] eu_opnd_o;
    logic           eu_vld_i;
    logic [DW-1:0]  eu_res_i;
    logic           wr_rel_o;
    logic           wr_go_i = 0;
    logic [DW-1:0]  data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    opcu_ctrl #(.DATA_W(DW), .OPC_W(OW), .NUM_RD(NR)) u_dut (.*);

    // Execution unit model: opcode 1 subtracts, anything else adds
    int            lat = 0;
    int            cnt = 0;
    logic [OW-1:0] c_opc;
    logic [DW-1:0] c_a, c_b, c_c;

    function automatic logic [DW-1:0] calc(input logic [OW-1:0] o, input logic [DW-1:0] a,
                                           input logic [DW-1:0] b, input logic [DW-1:0] c);
        return (o == 4'd1) ? DW'(a - b - c) : DW'(a + b + c);
    endfunction

    always @(posedge clk) begin
        if (eu_go_o && lat > 0) begin
            cnt   <= lat;
            c_opc <= eu_opc_o;
            c_a   <= eu_opnd_o[0 +: DW];
            c_b   <= eu_opnd_o[DW +: DW];
            c_c   <= eu_opnd_o[2*DW +: DW];
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
        end
    end

    assign eu_vld_i = (lat == 0) ? eu_go_o : (cnt == 1);
    assign eu_res_i = (lat == 0) ? calc(eu_opc_o, eu_opnd_o[0 +: DW], eu_opnd_o[DW +: DW], eu_opnd_o[2*DW +: DW])
                                 : calc(c_opc, c_a, c_b, c_c);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Generic operation driver; each scenario task below calls it
    task automatic run_op(input logic [OW-1:0] opc, input bit inv, input bit zero, input bit immv,
                          input logic [DW-1:0] imm, input logic [NR-1:0] mask,
                          input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] c,
                          input int delay1, input bit together, input int latency,
                          input int wrdelay, input bit stray, input logic [DW-1:0] exp);
        logic [NR-1:0] need;
        logic [DW-1:0] vals [NR];
        vals[0] = a; vals[1] = b; vals[2] = c;
        need[0] = !zero && !mask[0];
        need[1] = !immv && !mask[1];
        need[2] = !mask[2];
        lat = latency;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 idle before issue", busy_o, 0);
        opc_i = opc; inv_a_i = inv; zero_a_i = zero; imm_vld_i = immv; imm_i = imm;
        rd_mask_i = mask; issue_i = 1;
        @(negedge clk);
        issue_i = 0;
        chk(busy_o == 1'b1, "R1 busy after issue", busy_o, 1);
        chk(rd_rel_o == need, "R3/R5 release pattern", rd_rel_o, need);
        // R2: disturb fields after capture
        opc_i = ~opc; inv_a_i = ~inv; zero_a_i = ~zero; imm_vld_i = ~immv; imm_i = ~imm;
        if (need == '0) chk(1'b1, "R9 no reads", 0, 0);
        if (together && need != '0) begin
            rd_go_i = need;
            for (int p = 0; p < NR; p++) src_i[p*DW +: DW] = vals[p];
            #1;
            if (need[1]) chk(eu_opnd_o[DW +: DW] == b, "R4 operand forwarded", eu_opnd_o[DW +: DW], b);
            @(negedge clk);
            rd_go_i = '0; src_i = '0;
            chk(rd_rel_o == '0, "R4 releases drop", rd_rel_o, 0);
        end else begin
            for (int p = 0; p < NR; p++) begin
                if (need[p]) begin
                    if (p == 1) begin
                        for (int d = 0; d < delay1; d++) begin
                            @(negedge clk);
                            chk(rd_rel_o[1] == 1'b1, "R3 release held", rd_rel_o[1], 1);
                        end
                    end
                    rd_go_i[p] = 1'b1;
                    src_i[p*DW +: DW] = vals[p];
                    #1;
                    if (p == 1) chk(eu_opnd_o[DW +: DW] == b, "R4 operand forwarded", eu_opnd_o[DW +: DW], b);
                    @(negedge clk);
                    rd_go_i = '0; src_i = '0;
                    chk(rd_rel_o[p] == 1'b0, "R4 release drops", rd_rel_o[p], 0);
                end
            end
        end
        for (int w = 0; w < 50 && !wr_rel_o; w++) @(negedge clk);
        chk(wr_rel_o == 1'b1, "R7 write release reached", wr_rel_o, 1);
        chk(data_o == exp, "R2/R5/R6/R7 result", data_o, exp);
        for (int d = 0; d < wrdelay; d++) begin
            if (stray) begin
                rd_go_i = '1; src_i = '1;
            end
            @(negedge clk);
            rd_go_i = '0; src_i = '0;
            chk(wr_rel_o && busy_o, "R8 held until write go", {wr_rel_o, busy_o}, 3);
            chk(data_o == exp, "R8 result held", data_o, exp);
            if (stray) chk(rd_rel_o == '0, "R4 stray go ignored", rd_rel_o, 0);
        end
        wr_go_i = 1;
        @(negedge clk);
        wr_go_i = 0;
        chk(!busy_o && !wr_rel_o, "R8 done after write go", {busy_o, wr_rel_o}, 0);
        rd_mask_i = '0;
    endtask

    task automatic t_reset();
        chk(busy_o == 0 && rd_rel_o == '0 && wr_rel_o == 0, "R1 reset state",
            {busy_o, rd_rel_o, wr_rel_o}, 0);
        repeat (5) begin
            @(negedge clk);
            chk(busy_o == 0, "R1 no spontaneous busy", busy_o, 0);
        end
    endtask

    task automatic t_add_masked_c();   // R3 R4 R5: port 2 masked, 5+2
        run_op(4'd0, 0, 0, 0, 16'd0, 3'b100, 16'd5, 16'd2, 16'd99, 0, 0, 2, 0, 0, 16'd7);
    endtask

    task automatic t_invert_comb();    // R6 R7: zero-latency unit
        run_op(4'd0, 1, 0, 0, 16'd0, 3'b100, 16'd5, 16'd2, 16'd0, 0, 0, 0, 0, 0, 16'd65532);
    endtask

    task automatic t_no_reads();       // R9 R5: zeroed A, immediate B
        run_op(4'd0, 0, 1, 1, 16'd9, 3'b100, 16'd77, 16'd88, 16'd0, 0, 0, 1, 0, 0, 16'd9);
    endtask

    task automatic t_three_delayed();  // R2 R3: B go withheld 3 cycles
        run_op(4'd0, 0, 0, 0, 16'd0, 3'b000, 16'd5, 16'd2, 16'd4, 3, 0, 3, 0, 0, 16'd11);
    endtask

    task automatic t_sub_together();   // R4 R8: simultaneous gos, late write go, stray go
        run_op(4'd1, 0, 0, 0, 16'd0, 3'b000, 16'd21, 16'd4, 16'd1, 0, 1, 1, 4, 1, 16'd16);
    endtask

    task automatic t_imm_b();          // R5: immediate replaces B, A read
        run_op(4'd0, 0, 0, 1, 16'd300, 3'b100, 16'd40, 16'd1, 16'd0, 0, 0, 0, 1, 0, 16'd340);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_add_masked_c();
        t_invert_comb();
        t_no_reads();
        t_three_delayed();
        t_sub_together();
        t_imm_b();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule